// File: doc/BRIEF.md
# Clock frequency meter

This block measures how fast an unknown clock runs by counting cycles of a fixed reference clock over a window of that clock's periods. One of several candidate clocks is picked by a select field. The window spans a programmable number of its periods. The reference-domain cycle count taken over that window is then returned as the result. The block runs entirely on the reference clock. The selected clock is treated as an asynchronous signal: it passes through a synchroniser and an edge detector before it can open or close the window.

Software drives the block through four 16-bit registers on a simple write/read port. The control register holds the source select, a reference-enable bit, a meter-enable bit and a read-only busy flag. A second register holds the window size, a third returns the result, and a fourth carries a soft-reset bit. The software sequence is as follows. Turn the reference on, then set the meter enable. Poll until busy clears, then read the result. Clear the meter enable before turning the reference off. With a 32 kHz source and a one-period window, a 26 MHz reference gives a result of about 794.

Top module: `fm_meter`

## Requirements
- R1: After reset, all four registers read as zero. Address 0 is control, 1 is window size, 2 is result and 3 is soft reset.
- R2: Read data is registered. `bus_rdata` shows the register addressed in the previous cycle. A write to address 2 is ignored. Control bit 3 cannot be written.
- R3: In control, bits [2:0] select source `tclk_in[code]` for codes 0 to 6, bit 4 enables the reference and bit 15 enables the meter. Busy (control bit 3) becomes 1 in the cycle after bit 15 changes from 0 to 1.
- R4: The result equals the number of reference cycles spanned by window_size+1 periods of the selected source. A window size of 0 gives exactly one period.
- R5: Busy clears when the window closes, and the result is valid from then on. The result holds until the next completed window or soft reset, even while bit 15 stays set.
- R6: The count saturates at 0xFFFF and does not wrap. A following measurement starts again from zero.
- R7: Clearing bit 15 during a window drops busy in the next cycle. It leaves the previous result unchanged, and no later completion occurs.
- R8: While the reference enable (bit 4) is 0, an enabled measurement makes no progress and busy stays 1.
- R9: Bit 8 of address 3 is the soft reset. While it is 1, busy and the result read as 0. After it is written back to 0, a new measurement needs a fresh 0-to-1 change of bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| tclk_in | input | NSRC | Candidate clocks under test, asynchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Registered read data of the previously addressed register |

## Verification
The hardest state to reach from the ports is counter saturation. It needs a window longer than 65535 reference cycles, so the stimulus uses the slowest source (794 reference cycles per period) with a window of 83 periods. A short measurement follows to show the counter restarts. Aborts and soft resets must land in the middle of a long window. The bench therefore starts a multi-period measurement on that slow source, waits a few hundred cycles, and then clears the enable or sets the soft reset. It then waits past the point where the window would have closed, to show that no late result appears.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_WIN  = 2'd1;
  localparam logic [ADDR_W-1:0] A_RES  = 2'd2;
  localparam logic [ADDR_W-1:0] A_SRST = 2'd3;

  localparam int B_BUSY  = 3;
  localparam int B_REFEN = 4;
  localparam int B_SRST  = 8;
  localparam int B_MEN   = 15;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_ARM  = 2'd1,
    W_RUN  = 2'd2
  } win_state_t;
endpackage

// File: rtl/fm_src_sync.sv
module fm_src_sync #(
  parameter int NSRC   = 7,
  parameter int SELW   = 3,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] tclk_in,
  input  logic [SELW-1:0] sel,
  output logic            rise
);
  logic              picked;
  logic [STAGES:0]   shq;

  // Source multiplexer: unused codes give a constant low level.
  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SELW'(i)) picked = tclk_in[i];
    end
  end

  // Synchroniser chain plus one history flop for edge detection.
  always_ff @(posedge clk) begin
    if (rst) shq <= '0;
    else     shq <= {shq[STAGES-1:0], picked};
  end

  assign rise = shq[STAGES-1] & ~shq[STAGES];

  // R4: a detected edge is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise) else $error("edge pulse longer than one cycle");
endmodule

// File: rtl/fm_window_ctrl.sv
module fm_window_ctrl import fm_pkg::*; #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             meter_en,
  input  logic             ref_en,
  input  logic             srst,
  input  logic             rise,
  input  logic [WIN_W-1:0] win,
  output logic             busy,
  output logic             arm_clr,
  output logic             run,
  output logic             done
);
  win_state_t       st;
  logic             men_q;
  logic [WIN_W-1:0] win_lat;
  logic [WIN_W-1:0] edges;
  logic             start;
  logic             ev;
  logic             live;

  assign start   = meter_en & ~men_q & ~srst;
  assign ev      = ref_en & rise;
  assign live    = meter_en & ~srst;
  assign arm_clr = (st == W_ARM) & ev & live;
  assign done    = (st == W_RUN) & ev & live & (edges == win_lat);
  assign run     = (st == W_RUN);
  assign busy    = (st != W_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= W_IDLE;
      men_q   <= 1'b0;
      win_lat <= '0;
      edges   <= '0;
    end else begin
      men_q <= meter_en;
      if (!live) begin
        st <= W_IDLE;
      end else if (start) begin
        st      <= W_ARM;
        win_lat <= win;
        edges   <= '0;
      end else begin
        case (st)
          W_ARM: if (ev) begin
            st    <= W_RUN;
            edges <= '0;
          end
          W_RUN: if (ev) begin
            if (edges == win_lat) st <= W_IDLE;
            else                  edges <= edges + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R3: busy follows a fresh enable by one cycle
  a_r3_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> busy) else $error("busy did not rise after enable");

  // R5: closing the window ends busy
  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy) else $error("busy still set after window end");

  // R7: removing the enable aborts at once
  a_r7_abort_drops_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && !meter_en) |=> !busy) else $error("abort did not clear busy");

  // R8: no reference, no progress
  a_r8_no_ref_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !ref_en && meter_en && !srst) |=> busy) else $error("window moved without reference");

  // R9: soft reset forces idle
  a_r9_srst_idle: assert property (@(posedge clk) disable iff (rst)
    srst |=> !busy) else $error("busy set during soft reset");
endmodule

// File: rtl/fm_ref_counter.sv
module fm_ref_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst,
  input  logic             clr,
  input  logic             inc,
  input  logic             done,
  output logic [CNT_W-1:0] result
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxt;

  assign nxt = (cnt == CMAX) ? CMAX : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      result <= '0;
    end else begin
      if (clr)      cnt <= '0;
      else if (inc) cnt <= nxt;
      if (srst)      result <= '0;
      else if (done) result <= nxt;
    end
  end

  // R6: a full counter stays full until cleared
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt == CMAX && !clr) |=> (cnt == CMAX)) else $error("counter wrapped");

  // R5: result only moves on completion or soft reset
  a_r5_result_held: assert property (@(posedge clk) disable iff (rst)
    (!done && !srst) |=> $stable(result)) else $error("result changed without completion");

  // R9: soft reset empties the result
  a_r9_result_cleared: assert property (@(posedge clk) disable iff (rst)
    srst |=> (result == '0)) else $error("result not cleared by soft reset");
endmodule

// File: rtl/fm_regs.sv
module fm_regs import fm_pkg::*; #(
  parameter int SELW  = 3,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic [CNT_W-1:0]  result,
  output logic [SELW-1:0]   sel,
  output logic              ref_en,
  output logic              meter_en,
  output logic              srst,
  output logic [REG_W-1:0]  win
);
  localparam logic [REG_W-1:0] CTRL_WMASK = REG_W'((1 << SELW) - 1)
                                          | (REG_W'(1) << B_REFEN)
                                          | (REG_W'(1) << B_MEN);
  localparam logic [REG_W-1:0] SRST_WMASK = REG_W'(1) << B_SRST;

  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] srst_q;
  logic [REG_W-1:0] rd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      srst_q <= '0;
      win    <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL:  ctrl_q <= bus_wdata & CTRL_WMASK;
        A_WIN:   win    <= bus_wdata;
        A_SRST:  srst_q <= bus_wdata & SRST_WMASK;
        default: ;
      endcase
    end
  end

  assign sel      = ctrl_q[SELW-1:0];
  assign ref_en   = ctrl_q[B_REFEN];
  assign meter_en = ctrl_q[B_MEN];
  assign srst     = srst_q[B_SRST];

  always_comb begin
    case (bus_addr)
      A_CTRL:  rd_d = ctrl_q | (REG_W'(busy) << B_BUSY);
      A_WIN:   rd_d = win;
      A_RES:   rd_d = REG_W'(result);
      default: rd_d = srst_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  // R2: the result address has no write path into the control fields
  a_r2_res_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_RES) |=> $stable(ctrl_q) && $stable(win) && $stable(srst_q))
    else $error("write to result address changed a register");
endmodule

// File: rtl/fm_meter.sv
module fm_meter import fm_pkg::*; #(
  parameter int NSRC        = 7,
  parameter int SELW        = 3,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   tclk_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata
);
  localparam int WIN_W = REG_W;

  logic [SELW-1:0]  sel;
  logic             ref_en;
  logic             meter_en;
  logic             srst;
  logic [WIN_W-1:0] win;
  logic             rise;
  logic             busy;
  logic             arm_clr;
  logic             run;
  logic             done;
  logic [CNT_W-1:0] result;

  fm_regs #(.SELW(SELW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .result(result),
    .sel(sel), .ref_en(ref_en), .meter_en(meter_en), .srst(srst), .win(win)
  );

  fm_src_sync #(.NSRC(NSRC), .SELW(SELW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .tclk_in(tclk_in), .sel(sel), .rise(rise)
  );

  fm_window_ctrl #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst(rst), .meter_en(meter_en), .ref_en(ref_en), .srst(srst),
    .rise(rise), .win(win), .busy(busy), .arm_clr(arm_clr), .run(run), .done(done)
  );

  fm_ref_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .srst(srst), .clr(arm_clr), .inc(run & ref_en),
    .done(done), .result(result)
  );
endmodule

// File: tb/test_fm_meter.sv
module test_fm_meter;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 7;
  localparam int HALF [NS] = '{397, 12, 25, 15, 2, 18, 5};
  localparam logic [15:0] REF = 16'h0010;
  localparam logic [15:0] MEN = 16'h8000;

  logic        clk;
  logic        rst;
  logic [NS-1:0] tclk;
  logic        wr;
  logic [1:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  int checks;
  int errors;
  int tcyc;
  int last_result;

  fm_meter i_fm_meter (
    .clk(clk), .rst(rst), .tclk_in(tclk),
    .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // Clocks under test: period 2*HALF reference cycles, changing at falling edges.
  initial begin
    tclk = '0;
    tcyc = 0;
    forever begin
      @(negedge clk);
      tcyc++;
      for (int i = 0; i < NS; i++) tclk[i] = ((tcyc / HALF[i]) % 2) == 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wait_idle(input int limit, output bit ok);
    logic [15:0] d;
    ok = 1'b0;
    for (int n = 0; n < limit; n++) begin
      rd_reg(2'd0, d);
      if (!d[3]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic measure(input int sel, input int win, input int exp, input string req);
    logic [15:0] d;
    bit ok;
    wr_reg(2'd0, REF | 16'(sel));
    wr_reg(2'd1, 16'(win));
    wr_reg(2'd0, REF | MEN | 16'(sel));
    tick(2);
    wait_idle(80000, ok);
    chk({req, " busy cleared"}, 32'(ok), 32'd1);
    rd_reg(2'd2, d);
    chk(req, 32'(d), 32'(exp));
    last_result = exp;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), d);
      chk("R1 reset value", 32'(d), 32'd0);
    end
  endtask

  task automatic t_busy_rise;
    logic [15:0] d;
    bit ok;
    wr_reg(2'd0, REF);
    wr_reg(2'd1, 16'd0);
    wr_reg(2'd0, REF | MEN);
    @(negedge clk);
    chk("R3 busy not yet set", 32'(rdata[3]), 32'd0);
    @(negedge clk);
    chk("R3 busy set one cycle after enable", 32'(rdata[3]), 32'd1);
    wait_idle(5000, ok);
    chk("R5 busy cleared at window end", 32'(ok), 32'd1);
    rd_reg(2'd2, d);
    chk("R4 one 32k period is 794", 32'(d), 32'd794);
    tick(2000);
    rd_reg(2'd2, d);
    chk("R5 result held with enable still set", 32'(d), 32'd794);
    last_result = 794;
  endtask

  task automatic t_sources;
    int sels [6] = '{1, 2, 3, 4, 5, 6};
    int wins [6] = '{2, 0, 5, 9, 1, 3};
    for (int k = 0; k < 6; k++)
      measure(sels[k], wins[k], (wins[k] + 1) * 2 * HALF[sels[k]], "R4 source select");
  endtask

  task automatic t_readonly;
    logic [15:0] d;
    wr_reg(2'd2, 16'h1234);
    rd_reg(2'd2, d);
    chk("R2 result write ignored", 32'(d), 32'(last_result));
    wr_reg(2'd0, REF | 16'h0008);
    tick(1);
    rd_reg(2'd0, d);
    chk("R2 busy bit not writable", 32'(d), 32'(REF));
    wr_reg(2'd1, 16'hABCD);
    rd_reg(2'd1, d);
    chk("R2 window readback", 32'(d), 32'hABCD);
  endtask

  task automatic t_abort;
    logic [15:0] d;
    wr_reg(2'd0, REF);
    wr_reg(2'd1, 16'd10);
    wr_reg(2'd0, REF | MEN);
    tick(500);
    rd_reg(2'd0, d);
    chk("R7 busy during window", 32'(d[3]), 32'd1);
    wr_reg(2'd0, REF);
    tick(1);
    rd_reg(2'd0, d);
    chk("R7 busy dropped after abort", 32'(d[3]), 32'd0);
    rd_reg(2'd2, d);
    chk("R7 result unchanged after abort", 32'(d), 32'(last_result));
    tick(9000);
    rd_reg(2'd2, d);
    chk("R7 no late completion", 32'(d), 32'(last_result));
  endtask

  task automatic t_no_ref;
    logic [15:0] d;
    wr_reg(2'd0, 16'd4);
    wr_reg(2'd1, 16'd0);
    wr_reg(2'd0, MEN | 16'd4);
    tick(200);
    rd_reg(2'd0, d);
    chk("R8 still busy without reference", 32'(d), 32'h800C);
    rd_reg(2'd2, d);
    chk("R8 result untouched", 32'(d), 32'(last_result));
    wr_reg(2'd0, 16'd0);
    tick(2);
  endtask

  task automatic t_saturate;
    measure(0, 82, 16'hFFFF, "R6 saturated count");
    measure(4, 0, 4, "R6 restart after saturation");
  endtask

  task automatic t_soft_reset;
    logic [15:0] d;
    wr_reg(2'd0, REF);
    wr_reg(2'd1, 16'd5);
    wr_reg(2'd0, REF | MEN);
    tick(300);
    wr_reg(2'd3, 16'h0100);
    tick(1);
    rd_reg(2'd3, d);
    chk("R9 soft reset bit reads back", 32'(d), 32'h0100);
    rd_reg(2'd0, d);
    chk("R9 busy cleared by soft reset", 32'(d[3]), 32'd0);
    rd_reg(2'd2, d);
    chk("R9 result cleared by soft reset", 32'(d), 32'd0);
    wr_reg(2'd3, 16'h0000);
    tick(6000);
    rd_reg(2'd0, d);
    chk("R9 no restart without new enable", 32'(d), 32'h8010);
    rd_reg(2'd2, d);
    chk("R9 result stays clear", 32'(d), 32'd0);
    measure(4, 1, 8, "R9 measurement after release");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    errors++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    last_result = 0;
    rst = 1'b1;
    wr = 1'b0;
    addr = 2'd0;
    wdata = 16'd0;
    tick(4);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_busy_rise();
    t_sources();
    t_readonly();
    t_abort();
    t_no_ref();
    t_saturate();
    t_soft_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule